// File: doc/BRIEF.md
# Fully Associative Write-Back Cache with Exact LRU

This block sits between a 32-bit processor and a slower main memory. It holds a small number of 16-byte lines, each made of four 32-bit words. Every lookup compares the incoming line address against all stored line addresses in the same cycle, one comparator per entry. A read or write that finds its line completes with a response one cycle after it is accepted, and it never touches memory.

On a miss the block picks an entry to overwrite. Empty entries are used first. Once every entry is in use, it picks the entry that has gone unreferenced for the longest time. Each entry holds an age rank to keep this order exact. If the chosen entry was modified, its whole line is written back to memory first. The missing line is then read in as one wide transfer. A write miss allocates the line and merges the stored bytes into it.

The processor request port is valid/ready. A request is taken on a clock edge where both `cpu_req_valid` and `cpu_req_ready` are high. Ready stays low from the edge that takes a missing request until the edge that raises its response. The response is a single-cycle `cpu_rsp_valid` pulse with no back-pressure, so the processor must take it. The memory request port is also valid/ready. The cache holds a request, with its address and data unchanged, until memory raises ready. Memory answers every request, read or write, with one `mem_rsp_valid` pulse in a later cycle.

Top module: `assoc_cache`

## Requirements
- R1: After reset no entry is valid and every port output is idle: `cpu_req_ready`=1, `cpu_rsp_valid`=0, `mem_req_valid`=0. The first access to any line therefore misses.
- R2: Address bits [31:4] name the line, bits [3:2] pick the word in the line, and bits [1:0] are ignored. A read returns the 32-bit word at that position. Word 0 is bits [31:0] of the 128-bit line and word 3 is bits [127:96].
- R3: A request that hits raises `cpu_rsp_valid` in the cycle after acceptance, keeps `cpu_req_ready` high, and issues no memory request.
- R4: On a write, bit b of `cpu_req_be` enables byte b, which is bits [8b+7:8b] of the word. Bytes whose enable is 0 keep their old value.
- R5: A miss issues exactly one memory read of its line address, with bits [3:0] zero. The response follows once that read returns.
- R6: While any entry is empty, a miss fills an empty entry and evicts nothing. Eight distinct lines can be loaded and then all hit.
- R7: With all entries valid, a miss replaces the line whose last reference, hit or fill, is the oldest.
- R8: A replaced line that was written while cached is sent to memory as one write of its full current contents, before the new line is read. A replaced line that was never written produces no memory write.
- R9: A write miss allocates the line, fetching it first, merges the enabled bytes, and marks it modified.
- R10: At most one entry matches any lookup.
- R11: `cpu_req_ready` is low for as long as a miss is using memory. A memory request whose ready is low is held with an unchanged address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can take a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_be | input | 4 | Byte enables for writes |
| cpu_req_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | 32 | Read data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | 32 | Line byte address, bits [3:0] zero |
| mem_req_wdata | output | 128 | Line being written back |
| mem_rsp_valid | input | 1 | Memory completion pulse |
| mem_rsp_rdata | input | 128 | Line returned by a read |

## Verification
A corrupted age rank does not show up as a wrong read value. It shows up later, as the wrong line being written back, or as a hit turning into a refetch, on the first miss after all entries are full. The bench therefore tracks recency order and the modified state of every line on its own side. On each miss it checks which line is written back, and whether any line is. A lost modified flag shows up only when that line is evicted: memory then keeps stale data, so every write-back is compared with the expected line contents. A wrong tag or valid bit shows up in the very next access, as an extra memory read or a response that comes one cycle early or late.

// File: rtl/acache_pkg.sv
package acache_pkg;
  localparam int WORD_W    = 32;
  localparam int LINE_WDS  = 4;
  localparam int LINE_W    = WORD_W * LINE_WDS;
  localparam int OFF_W     = 4;
  localparam int WSEL_W    = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB_REQ,
    ST_WB_WAIT,
    ST_FILL_REQ,
    ST_FILL_WAIT
  } ctl_state_t;

  function automatic logic [LINE_W-1:0] merge_word(
    input logic [LINE_W-1:0] line,
    input logic [WSEL_W-1:0] sel,
    input logic [3:0]        be,
    input logic [WORD_W-1:0] wd
  );
    logic [LINE_W-1:0] res;
    res = line;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) res[int'(sel)*WORD_W + b*8 +: 8] = wd[b*8 +: 8];
    end
    return res;
  endfunction

  function automatic logic [WORD_W-1:0] pick_word(
    input logic [LINE_W-1:0] line,
    input logic [WSEL_W-1:0] sel
  );
    return line[int'(sel)*WORD_W +: WORD_W];
  endfunction
endpackage

// File: rtl/acache_tag_cam.sv
module acache_tag_cam #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 28,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             any_free,
  output logic [IDX_W-1:0] free_idx,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
    end else if (fill_en) begin
      valid_q[fill_idx] <= 1'b1;
      tag_q[fill_idx]   <= fill_tag;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = valid_q[e] && (tag_q[e] == look_tag);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end

  assign hit      = |hit_vec;
  assign any_free = ~&valid_q;
  assign rd_tag   = tag_q[rd_idx];

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R10
  AST_FILL_FREE_OR_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !hit); // R10
endmodule

// File: rtl/acache_lru.sv
module acache_lru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] oldest_idx
);
  localparam logic [IDX_W-1:0] MAX_AGE = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [ENTRIES-1:0] oldest_vec, newest_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)        age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_rank
    assign oldest_vec[e] = (age_q[e] == MAX_AGE);
    assign newest_vec[e] = (age_q[e] == '0);
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (oldest_vec[i]) oldest_idx = IDX_W'(i);
    end
  end

  AST_SINGLE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1); // R7
  AST_SINGLE_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(newest_vec) == 1); // R7
  AST_TOUCH_NOT_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> !oldest_vec[$past(touch_idx)]); // R7
endmodule

// File: rtl/acache_lines.sv
module acache_lines
  import acache_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              wr_dirty,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  output logic              rd_dirty
);
  logic [LINE_W-1:0]  data_q [ENTRIES];
  logic [ENTRIES-1:0] dirty_q;

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx] <= wr_line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dirty_q <= '0;
    else if (wr_en) dirty_q[wr_idx] <= wr_dirty;
  end

  assign rd_line  = data_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
  import acache_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [3:0]        cpu_req_be,
  input  logic [WORD_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [WORD_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_rdata
);
  ctl_state_t state_q;

  logic [TAG_W-1:0]  r_tag;
  logic [WSEL_W-1:0] r_word;
  logic              r_write;
  logic [3:0]        r_be;
  logic [WORD_W-1:0] r_wdata;
  logic [IDX_W-1:0]  r_victim;

  logic              hit, any_free;
  logic [IDX_W-1:0]  hit_idx, free_idx, oldest_idx, victim_sel;
  logic [TAG_W-1:0]  victim_tag;
  logic [LINE_W-1:0] line_q, hit_line_new, fill_line, wr_line;
  logic              line_dirty;
  logic              accept, hit_acc, miss_acc, fill_done;
  logic              wr_en, wr_dirty, touch_en;
  logic [IDX_W-1:0]  wr_idx, touch_idx, line_rd_idx;
  logic [TAG_W-1:0]  in_tag;
  logic [WSEL_W-1:0] in_word;
  logic [OFF_W-WSEL_W-1:0] unused_byte_bits;

  assign in_tag           = cpu_req_addr[ADDR_W-1:OFF_W];
  assign in_word          = cpu_req_addr[OFF_W-1:OFF_W-WSEL_W];
  assign unused_byte_bits = cpu_req_addr[OFF_W-WSEL_W-1:0];

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign hit_acc       = accept && hit;
  assign miss_acc      = accept && !hit;
  assign fill_done     = (state_q == ST_FILL_WAIT) && mem_rsp_valid;
  assign victim_sel    = any_free ? free_idx : oldest_idx;
  assign line_rd_idx   = (state_q == ST_IDLE) ? hit_idx : r_victim;

  assign hit_line_new = merge_word(line_q, in_word, cpu_req_be, cpu_req_wdata);
  assign fill_line    = r_write ? merge_word(mem_rsp_rdata, r_word, r_be, r_wdata)
                                : mem_rsp_rdata;

  assign wr_en     = (hit_acc && cpu_req_write) || fill_done;
  assign wr_idx    = fill_done ? r_victim : hit_idx;
  assign wr_line   = fill_done ? fill_line : hit_line_new;
  assign wr_dirty  = fill_done ? r_write : 1'b1;
  assign touch_en  = hit_acc || fill_done;
  assign touch_idx = fill_done ? r_victim : hit_idx;

  assign mem_req_valid = (state_q == ST_WB_REQ) || (state_q == ST_FILL_REQ);
  assign mem_req_write = (state_q == ST_WB_REQ);
  assign mem_req_addr  = (state_q == ST_WB_REQ) ? {victim_tag, {OFF_W{1'b0}}}
                                                : {r_tag, {OFF_W{1'b0}}};
  assign mem_req_wdata = line_q;

  acache_tag_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_tag (in_tag),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .any_free (any_free),
    .free_idx (free_idx),
    .fill_en  (fill_done),
    .fill_idx (r_victim),
    .fill_tag (r_tag),
    .rd_idx   (r_victim),
    .rd_tag   (victim_tag)
  );

  acache_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .oldest_idx (oldest_idx)
  );

  acache_lines #(.ENTRIES(ENTRIES)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_line  (wr_line),
    .wr_dirty (wr_dirty),
    .rd_idx   (line_rd_idx),
    .rd_line  (line_q),
    .rd_dirty (line_dirty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      r_tag         <= '0;
      r_word        <= '0;
      r_write       <= 1'b0;
      r_be          <= '0;
      r_wdata       <= '0;
      r_victim      <= '0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
    end else begin
      cpu_rsp_valid <= hit_acc || fill_done;
      if (hit_acc)   cpu_rsp_rdata <= pick_word(line_q, in_word);
      if (fill_done) cpu_rsp_rdata <= pick_word(fill_line, r_word);
      unique case (state_q)
        ST_IDLE: if (miss_acc) begin
          r_tag    <= in_tag;
          r_word   <= in_word;
          r_write  <= cpu_req_write;
          r_be     <= cpu_req_be;
          r_wdata  <= cpu_req_wdata;
          r_victim <= victim_sel;
          state_q  <= ST_FILL_REQ;
          if (!any_free) begin
            if (u_lines.dirty_q[victim_sel]) state_q <= ST_WB_REQ;
          end
        end
        ST_WB_REQ:    if (mem_req_ready) state_q <= ST_WB_WAIT;
        ST_WB_WAIT:   if (mem_rsp_valid) state_q <= ST_FILL_REQ;
        ST_FILL_REQ:  if (mem_req_ready) state_q <= ST_FILL_WAIT;
        ST_FILL_WAIT: if (mem_rsp_valid) state_q <= ST_IDLE;
        default:      state_q <= ST_IDLE;
      endcase
    end
  end

  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> line_dirty); // R8
  AST_NO_READY_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cpu_req_ready); // R11
  AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    hit_acc |=> !mem_req_valid); // R3
  AST_RSP_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> cpu_req_ready); // R3
endmodule

// File: tb/assoc_cache_test.sv
module assoc_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 3;
  localparam int NLINES     = 64;
  localparam int WAYS       = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req_valid = 1'b0;
  logic         cpu_req_ready;
  logic         cpu_req_write = 1'b0;
  logic [31:0]  cpu_req_addr = '0;
  logic [3:0]   cpu_req_be = '0;
  logic [31:0]  cpu_req_wdata = '0;
  logic         cpu_rsp_valid;
  logic [31:0]  cpu_rsp_rdata;
  logic         mem_req_valid;
  logic         mem_req_ready;
  logic         mem_req_write;
  logic [31:0]  mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic         mem_rsp_valid;
  logic [127:0] mem_rsp_rdata;

  int total = 0;
  int bad = 0;
  int hold_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc_cache uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_be(cpu_req_be), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  function automatic logic [31:0] init_word(int ln, int w);
    return 32'h5A00_0000 | 32'(ln << 8) | 32'(w << 2) | 32'h0000_0003;
  endfunction

  function automatic logic [31:0] line_addr(int ln, int w);
    return 32'hABC0_0000 | 32'(ln << 4) | 32'(w << 2);
  endfunction

  // memory model with latency and alternating back-pressure
  logic [127:0] mline [NLINES];
  int  busy;
  int  rd_cnt, wr_cnt, last_wr;
  int  p_idx;
  int  cyc;
  logic        prev_hold;
  logic [31:0] prev_addr;

  assign mem_req_ready = (busy == 0) && !mem_rsp_valid && cyc[0];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NLINES; l++)
        for (int w = 0; w < 4; w++) mline[l][w*32 +: 32] <= init_word(l, w);
      busy <= 0; rd_cnt <= 0; wr_cnt <= 0; last_wr <= -1; p_idx <= 0; cyc <= 0;
      mem_rsp_valid <= 1'b0; mem_rsp_rdata <= '0; prev_hold <= 1'b0; prev_addr <= '0;
    end else begin
      cyc <= cyc + 1;
      mem_rsp_valid <= 1'b0;
      if (busy > 0) begin
        busy <= busy - 1;
        if (busy == 1) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= mline[p_idx];
        end
      end
      if (prev_hold && (!mem_req_valid || mem_req_addr != prev_addr)) hold_err <= hold_err + 1;
      prev_hold <= mem_req_valid && !mem_req_ready;
      prev_addr <= mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        busy  <= MEM_LAT;
        p_idx <= int'(mem_req_addr[9:4]);
        if (mem_req_write) begin
          mline[mem_req_addr[9:4]] <= mem_req_wdata;
          wr_cnt  <= wr_cnt + 1;
          last_wr <= int'(mem_req_addr[9:4]);
        end else rd_cnt <= rd_cnt + 1;
      end
    end
  end

  // bench-side reference: processor view of memory, recency list, modified flags
  logic [31:0] ref_mem [NLINES][4];
  bit          mod_flag [NLINES];
  int          lst [WAYS];
  int          lst_n = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int ln, input int w, input logic [3:0] be,
                        input logic [31:0] wd);
    int pos, victim, rd0, wr0, lat;
    bit evict, ready_bad;
    logic [127:0] exp_line;
    logic [31:0] got;
    pos = -1;
    for (int i = 0; i < lst_n; i++) if (lst[i] == ln) pos = i;
    evict  = (pos < 0) && (lst_n == WAYS);
    victim = evict ? lst[WAYS-1] : -1;
    rd0 = rd_cnt; wr0 = wr_cnt;
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_be = be; cpu_req_wdata = wd;
    cpu_req_addr  = line_addr(ln, w) | 32'(ln & 3);
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    lat = 1; ready_bad = 0;
    while (!cpu_rsp_valid && lat < 200) begin
      if (cpu_req_ready) ready_bad = 1;
      @(negedge clk);
      lat++;
    end
    got = cpu_rsp_rdata;
    chk(!ready_bad, "R11 ready low during miss", 128'(ready_bad), 0);
    if (pos >= 0) begin
      chk(lat == 1, "R3 hit latency", 128'(lat), 1);
      chk(rd_cnt == rd0, "R3 hit no memory read", 128'(rd_cnt - rd0), 0);
    end else begin
      chk(rd_cnt - rd0 == 1, "R5 one line read on miss", 128'(rd_cnt - rd0), 1);
    end
    if (evict && mod_flag[victim]) begin
      chk(wr_cnt - wr0 == 1, "R8 write-back of modified victim", 128'(wr_cnt - wr0), 1);
      chk(last_wr == victim, "R7 LRU victim line", 128'(last_wr), 128'(victim));
      for (int k = 0; k < 4; k++) exp_line[k*32 +: 32] = ref_mem[victim][k];
      chk(mline[victim] == exp_line, "R8 write-back contents", mline[victim], exp_line);
    end else begin
      chk(wr_cnt == wr0, "R8 no write-back for clean or free entry", 128'(wr_cnt - wr0), 0);
    end
    if (!wr) chk(got == ref_mem[ln][w], "R2 read data", 128'(got), 128'(ref_mem[ln][w]));
    if (wr) begin
      for (int b = 0; b < 4; b++) if (be[b]) ref_mem[ln][w][b*8 +: 8] = wd[b*8 +: 8];
      mod_flag[ln] = 1'b1;
    end
    if (evict) mod_flag[victim] = 1'b0;
    if (pos < 0) begin
      if (lst_n < WAYS) lst_n++;
      pos = lst_n - 1;
    end
    for (int i = pos; i > 0; i--) lst[i] = lst[i-1];
    lst[0] = ln;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    int ln, w, lat;
    for (int l = 0; l < NLINES; l++) begin
      mod_flag[l] = 1'b0;
      for (int k = 0; k < 4; k++) ref_mem[l][k] = init_word(l, k);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R1 ready after reset", 128'(cpu_req_ready), 1);
    chk(cpu_rsp_valid == 1'b0, "R1 no response after reset", 128'(cpu_rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R1 no memory request after reset", 128'(mem_req_valid), 0);

    // R1 R6: eight distinct lines miss into free entries
    for (int l = 0; l < WAYS; l++) access(0, l, l & 3, 4'h0, 0);
    // R6 R2 R10: sweep every word of the eight lines, all hit
    for (int l = 0; l < WAYS; l++)
      for (int k = 0; k < 4; k++) access(0, l, k, 4'h0, 0);

    // R4: every byte-enable pattern on one word, read back
    for (int b = 0; b < 16; b++) begin
      access(1, 2, 1, 4'(b), 32'h1122_3344 ^ (32'(b) * 32'h0101_0101));
      access(0, 2, 1, 4'h0, 0);
    end

    // R9 R7: write miss allocates; victim is least recently used line
    access(1, 20, 3, 4'hF, 32'hDEAD_BEEF);
    access(0, 20, 3, 4'h0, 0);
    chk(mod_flag[20], "R9 write miss marks line modified", 128'(mod_flag[20]), 1);

    // R7 R8: pseudo-random mix over twelve lines
    seed = 32'h1234_5678;
    for (int n = 0; n < 600; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      ln = 30 + int'(seed[20:17]) % 12;
      w  = int'(seed[22:21]);
      access(seed[25:24] == 2'b00, ln, w, seed[29:26], seed ^ 32'hA5A5_0F0F);
    end

    // R3: hit keeps ready high in the response cycle
    access(0, lst[0], 0, 4'h0, 0);
    lat = 0;
    chk(cpu_req_ready == 1'b1, "R3 ready stays high on hit", 128'(cpu_req_ready), 1);

    chk(hold_err == 0, "R11 memory request held under back-pressure", 128'(hold_err), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule